// File: doc/BRIEF.md
# Serial Flash Sequencer Register Front-End

This block sits between a register bus and a serial-flash command engine. Software first loads a flash byte address into an address register. It then writes one control/status word that carries four things at once: the operation kind, the transfer length minus one, a launch bit, and write-one-to-clear bits for the sticky completion and failure flags.

When the launch is accepted, the block presents one command to the downstream engine. The command holds the operation, the latched address and a byte length. It stays presented until the engine acknowledges it. The acknowledgement either finishes the operation cleanly or flags it as failed. A 64-byte staging buffer holds the payload. Software loads it through byte-lane enables before a program operation and empties it after a read or status operation. The engine reaches the same buffer one byte at a time while the operation is running.

Register words are decoded on 4-byte boundaries. Address offset 0x00 is the flash address. Offset 0x04 is control/status. Offsets 0x40 to 0x7F are the staging buffer, with byte i held in word i/4, byte lane i%4. The reset input is asynchronous when asserted; its release is synchronised to the clock inside the block.

Top module: `flash_seq_frontend`

## Requirements
- R1: After reset, the control/status word reads 0, the address register reads 0 and `cmd_req` is low.
- R2: The address register accepts per-byte-lane writes and reads back unchanged. Address bits [1:0] are ignored for register accesses, so offsets 0x02 and 0x03 reach the word at 0x00. A launch uses the address register value present at the launch write.
- R3: Control/status layout: bit 0 done, bit 1 failed, bit 2 busy, bit 8 launch, bits [12:10] operation, bits [23:16] length minus one. Operation codes: 0 read, 1 page program, 2 erase 4 KiB, 3 erase 64 KiB, 4 read status. A launch write while idle raises `cmd_req` and busy on the next clock. `cmd_type` is the operation from that same write, and `cmd_len` is the length field plus one.
- R4: `cmd_req`, `cmd_type`, `cmd_addr` and `cmd_len` hold steady until `cmd_ack`. The clock edge that samples `cmd_ack` clears busy and `cmd_req` and sets done when `cmd_err` is low.
- R5: Erase operations (codes 2 and 3) present `cmd_len` = 0 whatever the length field holds.
- R6: Writing 1 to bit 0 or bit 1 clears done or failed respectively. Writing 0 to either leaves it unchanged. A launch write can clear stale flags in the same access.
- R7: A launch write while busy starts nothing and leaves the presented command unchanged.
- R8: A launch whose length field is 64 or more sets failed and does not raise `cmd_req`.
- R9: A launch with operation code 5, 6 or 7 sets failed and does not raise `cmd_req`.
- R10: Host buffer writes honour byte-lane enables. While a command is presented, the engine reads buffer byte i through `eng_buf_rdata`.
- R11: While busy, engine writes land at buffer byte `eng_buf_idx`, and software can read them afterwards.
- R12: Host writes to the buffer are ignored while busy.
- R13: An acknowledgement with `cmd_err` high sets failed and leaves done clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cmd_req | output | 1 | Command presented to engine |
| cmd_type | output | 3 | Operation code |
| cmd_addr | output | 32 | Flash byte address |
| cmd_len | output | 7 | Data byte count (0 for erase) |
| cmd_ack | input | 1 | Engine acknowledgement |
| cmd_err | input | 1 | Failure qualifier with `cmd_ack` |
| eng_buf_we | input | 1 | Engine buffer byte write |
| eng_buf_idx | input | 6 | Engine buffer byte index |
| eng_buf_wdata | input | 8 | Engine buffer write byte |
| eng_buf_rdata | output | 8 | Engine buffer read byte |

## Verification
Some properties are checked on every cycle by assertions. The presented command stays frozen until it is acknowledged. An acknowledgement resolves into done or failed on the next edge. Launches that are oversized, carry an unknown code, or arrive while busy never start a command. Erase commands always show a zero length. Other behaviour can only be shown by the bench's scenarios. These include byte-lane merging in the buffer, data passing both ways between host and engine, host buffer writes being dropped while busy, write-one-to-clear acting on stale flags, and the order and content of commands against the scoreboard.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam int CS_DONE    = 0;
  localparam int CS_ERR     = 1;
  localparam int CS_BUSY    = 2;
  localparam int CS_GO      = 8;
  localparam int CS_TYPE_LO = 10;
  localparam int TYPE_W     = 3;
  localparam int CS_CNT_LO  = 16;
  localparam int CNT_W      = 8;

  typedef enum logic [TYPE_W-1:0] {
    CYC_READ     = 3'd0,
    CYC_PROG     = 3'd1,
    CYC_ERASE4K  = 3'd2,
    CYC_ERASE64K = 3'd3,
    CYC_RDSTS    = 3'd4
  } cyc_e;
endpackage

// File: rtl/fsq_buffer.sv
module fsq_buffer #(
  parameter int BUF_BYTES = 64,
  localparam int IDX_W = $clog2(BUF_BYTES),
  localparam int WI_W = IDX_W - 2,
  localparam int WORDS = BUF_BYTES / 4
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [WI_W-1:0]  host_word,
  input  logic [3:0]       host_be,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [7:0]       eng_wdata,
  output logic [7:0]       eng_rdata
);
  logic [WI_W-1:0] eng_word;
  logic [1:0]      eng_lane;
  logic [7:0]      lane_rd [4];

  assign eng_word = eng_idx[IDX_W-1:2];
  assign eng_lane = eng_idx[1:0];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic       we_e, we_h;
    logic [WI_W-1:0] wa;
    logic [7:0]      wd;

    always_comb begin
      we_e = eng_we && (eng_lane == 2'(g));
      we_h = host_we && host_be[g];
      wa   = we_e ? eng_word : host_word;
      wd   = we_e ? eng_wdata : host_wdata[8*g +: 8];
    end

    always_ff @(posedge clk) begin
      if (we_e || we_h) mem[wa] <= wd;
    end

    assign host_rdata[8*g +: 8] = mem[host_word];
    assign lane_rd[g]           = mem[eng_word];
  end

  assign eng_rdata = lane_rd[eng_lane];
endmodule

// File: rtl/fsq_dispatch.sv
module fsq_dispatch
  import fsq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUF_BYTES = 64,
  parameter int LEN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [31:0]       ctrl_wdata,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              cmd_ack,
  input  logic              cmd_err,
  output logic              cmd_req,
  output logic [TYPE_W-1:0] cmd_type,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [31:0]       stat_word
);
  logic              busy_q, busy_d, done_q, done_d, err_q, err_d;
  logic [TYPE_W-1:0] type_q, type_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_l_q, addr_l_d;
  logic [LEN_W-1:0]  len_q, len_d;

  logic              w_go, w_clr_done, w_clr_err, type_ok, too_long, launch_try, w_erase;
  logic [TYPE_W-1:0] w_type;
  logic [CNT_W-1:0]  w_cnt;

  always_comb begin
    w_go       = ctrl_wdata[CS_GO];
    w_clr_done = ctrl_wdata[CS_DONE];
    w_clr_err  = ctrl_wdata[CS_ERR];
    w_type     = ctrl_wdata[CS_TYPE_LO +: TYPE_W];
    w_cnt      = ctrl_wdata[CS_CNT_LO +: CNT_W];
    type_ok    = (w_type <= TYPE_W'(CYC_RDSTS));
    too_long   = (int'(w_cnt) >= BUF_BYTES);
    w_erase    = (w_type == TYPE_W'(CYC_ERASE4K)) || (w_type == TYPE_W'(CYC_ERASE64K));
    launch_try = ctrl_wr && w_go && !busy_q;
  end

  always_comb begin
    busy_d   = busy_q;
    done_d   = done_q;
    err_d    = err_q;
    type_d   = type_q;
    cnt_d    = cnt_q;
    addr_l_d = addr_l_q;
    len_d    = len_q;
    if (ctrl_wr && w_clr_done) done_d = 1'b0;
    if (ctrl_wr && w_clr_err)  err_d  = 1'b0;
    if (busy_q && cmd_ack) begin
      busy_d = 1'b0;
      if (cmd_err) err_d = 1'b1;
      else         done_d = 1'b1;
    end else if (launch_try) begin
      type_d = w_type;
      cnt_d  = w_cnt;
      if (!type_ok || too_long) begin
        err_d = 1'b1;
      end else begin
        busy_d   = 1'b1;
        addr_l_d = addr_q;
        len_d    = w_erase ? '0 : LEN_W'(w_cnt) + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      type_q   <= '0;
      cnt_q    <= '0;
      addr_l_q <= '0;
      len_q    <= '0;
    end else begin
      busy_q   <= busy_d;
      done_q   <= done_d;
      err_q    <= err_d;
      type_q   <= type_d;
      cnt_q    <= cnt_d;
      addr_l_q <= addr_l_d;
      len_q    <= len_d;
    end
  end

  assign cmd_req  = busy_q;
  assign cmd_type = type_q;
  assign cmd_addr = addr_l_q;
  assign cmd_len  = len_q;

  always_comb begin
    stat_word = '0;
    stat_word[CS_DONE] = done_q;
    stat_word[CS_ERR]  = err_q;
    stat_word[CS_BUSY] = busy_q;
    stat_word[CS_TYPE_LO +: TYPE_W] = type_q;
    stat_word[CS_CNT_LO +: CNT_W]   = cnt_q;
  end

  // R4: presented command frozen until acknowledged
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_addr) && $stable(cmd_type) && $stable(cmd_len)));
  // R4: clean acknowledgement resolves to done
  assert_ack_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_ack && !cmd_err) |=> (!cmd_req && done_q));
  // R13: failing acknowledgement resolves to failed
  assert_ack_fail_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_ack && cmd_err) |=> (!cmd_req && err_q));
  // R5: erase commands carry no data
  assert_erase_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && (cmd_type == TYPE_W'(CYC_ERASE4K) || cmd_type == TYPE_W'(CYC_ERASE64K))) |-> (cmd_len == '0));
  // R7: launch while busy is ignored
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && w_go && cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_addr) && $stable(cmd_type)));
  // R8: oversized launch fails without starting
  assert_oversize_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && w_go && !cmd_req && int'(w_cnt) >= BUF_BYTES) |=> (err_q && !cmd_req));
  // R9: unknown operation fails without starting
  assert_bad_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && w_go && !cmd_req && w_type > TYPE_W'(CYC_RDSTS)) |=> (err_q && !cmd_req));
endmodule

// File: rtl/fsq_regs.sv
module fsq_regs #(
  parameter int ADDR_W = 32,
  parameter int BUF_BYTES = 64,
  localparam int IDX_W = $clog2(BUF_BYTES),
  localparam int RA_W = IDX_W + 2,
  localparam int WI_W = IDX_W - 2,
  localparam int NB = ADDR_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  input  logic [31:0]       stat_word,
  input  logic [31:0]       buf_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ctrl_wr,
  output logic              buf_we,
  output logic [WI_W-1:0]   buf_word,
  output logic [31:0]       reg_rdata
);
  logic            in_buf, addr_wr;
  logic [WI_W-1:0] word_sel;

  always_comb begin
    in_buf   = reg_addr[IDX_W];
    word_sel = reg_addr[IDX_W-1:2];
    addr_wr  = reg_wr && !in_buf && (word_sel == WI_W'(0));
    ctrl_wr  = reg_wr && !in_buf && (word_sel == WI_W'(1));
    buf_we   = reg_wr && in_buf && !busy;
    buf_word = word_sel;
  end

  for (genvar b = 0; b < NB; b++) begin : g_abyte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        addr_q[8*b +: 8] <= '0;
      else if (addr_wr && reg_be[b % 4]) addr_q[8*b +: 8] <= reg_wdata[8*(b % 4) +: 8];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_buf)                        reg_rdata = buf_rdata;
    else if (word_sel == WI_W'(0))     reg_rdata = 32'(addr_q);
    else if (word_sel == WI_W'(1))     reg_rdata = stat_word;
  end
endmodule

// File: rtl/flash_seq_frontend.sv
module flash_seq_frontend
  import fsq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUF_BYTES = 64,
  localparam int IDX_W = $clog2(BUF_BYTES),
  localparam int RA_W = IDX_W + 2,
  localparam int LEN_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cmd_req,
  output logic [TYPE_W-1:0] cmd_type,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_ack,
  input  logic              cmd_err,
  input  logic              eng_buf_we,
  input  logic [IDX_W-1:0]  eng_buf_idx,
  input  logic [7:0]        eng_buf_wdata,
  output logic [7:0]        eng_buf_rdata
);
  localparam int WI_W = IDX_W - 2;

  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic [ADDR_W-1:0] addr_q;
  logic              ctrl_wr, buf_we;
  logic [WI_W-1:0]   buf_word;
  logic [31:0]       stat_word, buf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  fsq_regs #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .busy(cmd_req),
    .stat_word(stat_word), .buf_rdata(buf_rdata), .addr_q(addr_q),
    .ctrl_wr(ctrl_wr), .buf_we(buf_we), .buf_word(buf_word), .reg_rdata(reg_rdata)
  );

  fsq_dispatch #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_disp (
    .clk(clk), .rst_n(rst_i_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(reg_wdata),
    .addr_q(addr_q), .cmd_ack(cmd_ack), .cmd_err(cmd_err), .cmd_req(cmd_req),
    .cmd_type(cmd_type), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .stat_word(stat_word)
  );

  fsq_buffer #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .host_we(buf_we), .host_word(buf_word), .host_be(reg_be),
    .host_wdata(reg_wdata), .host_rdata(buf_rdata),
    .eng_we(eng_buf_we && cmd_req), .eng_idx(eng_buf_idx),
    .eng_wdata(eng_buf_wdata), .eng_rdata(eng_buf_rdata)
  );
endmodule

// File: tb/test_flash_seq_frontend.sv
module test_flash_seq_frontend;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cmd_req, cmd_ack, cmd_err;
  logic [2:0]  cmd_type;
  logic [31:0] cmd_addr;
  logic [6:0]  cmd_len;
  logic        eng_buf_we;
  logic [5:0]  eng_buf_idx;
  logic [7:0]  eng_buf_wdata, eng_buf_rdata;

  always #2 clk = ~clk;

  flash_seq_frontend i_flash_seq_frontend (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_req(cmd_req), .cmd_type(cmd_type),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_ack(cmd_ack), .cmd_err(cmd_err),
    .eng_buf_we(eng_buf_we), .eng_buf_idx(eng_buf_idx), .eng_buf_wdata(eng_buf_wdata),
    .eng_buf_rdata(eng_buf_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [41:0] exp_q [$];
  logic [7:0]  seen [64];
  logic        resp_err = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] ctl(input bit go, input logic [2:0] t, input logic [7:0] c,
                                      input bit clr_d, input bit clr_e);
    return {8'h0, c, 3'b0, t, 1'b0, go, 6'b0, clr_e, clr_d};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic launch(input logic [2:0] t, input logic [7:0] c, input bit clr, input bit expect_go,
                        input logic [31:0] a, input logic [6:0] l);
    if (expect_go) exp_q.push_back({t, a, l});
    wr(8'h04, ctl(1'b1, t, c, clr, clr), 4'hF);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      rd(8'h04, s);
      if (!s[2]) break;
      @(negedge clk);
    end
  endtask

  // Engine model: moves data, then acknowledges
  initial begin
    cmd_ack = 1'b0; cmd_err = 1'b0; eng_buf_we = 1'b0; eng_buf_idx = '0; eng_buf_wdata = '0;
    forever begin
      @(negedge clk);
      if (cmd_req && !cmd_ack) begin
        if (cmd_type == 3'd0) begin
          for (int i = 0; i < int'(cmd_len); i++) begin
            eng_buf_we = 1'b1; eng_buf_idx = 6'(i); eng_buf_wdata = 8'hA0 + 8'(i);
            @(negedge clk);
          end
          eng_buf_we = 1'b0;
        end else if (cmd_type == 3'd1) begin
          for (int i = 0; i < int'(cmd_len); i++) begin
            eng_buf_idx = 6'(i); #1 seen[i] = eng_buf_rdata;
            @(negedge clk);
          end
        end
        repeat (4) @(negedge clk);
        cmd_ack = 1'b1; cmd_err = resp_err;
        @(negedge clk);
        cmd_ack = 1'b0; cmd_err = 1'b0;
      end
    end
  end

  // Scoreboard monitor: each new command must match the next expected one
  logic prev_req = 1'b0;
  always @(negedge clk) begin
    if (cmd_req && !prev_req) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R3/R7/R8/R9 unexpected command actual=0x%011h expected=none", {cmd_type, cmd_addr, cmd_len});
      end else begin
        chk("R3 command", {22'b0, cmd_type, cmd_len}, {22'b0, exp_q[0][41:39], exp_q[0][6:0]});
        chk("R2 command address", cmd_addr, exp_q[0][38:7]);
        void'(exp_q.pop_front());
      end
    end
    prev_req = cmd_req;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_be = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h04, d); chk("R1 status", d, 32'h0);
    rd(8'h00, d); chk("R1 address", d, 32'h0);
    chk("R1 cmd_req", {31'b0, cmd_req}, 32'h0);

    // R2 unaligned offsets reach the address word; byte lanes
    wr(8'h02, 32'h0012_3400, 4'hF);
    rd(8'h03, d); chk("R2 address readback", d, 32'h0012_3400);
    wr(8'h01, 32'hFFFF_FF77, 4'h1);
    rd(8'h00, d); chk("R2 address byte lane", d, 32'h0012_3477);

    // R10 buffer byte lanes
    wr(8'h40, 32'hAABB_CCDD, 4'hF);
    wr(8'h41, 32'h0000_5500, 4'h2);
    wr(8'h44, 32'h1122_3344, 4'hF);
    wr(8'h48, 32'h0F0F_0F0F, 4'hF);
    rd(8'h40, d); chk("R10 lane merge", d, 32'hAABB_55DD);

    // R3 program launch of 8 bytes
    launch(3'd1, 8'd7, 1'b1, 1'b1, 32'h0012_3477, 7'd8);
    chk("R3 req next clock", {31'b0, cmd_req}, 32'h1);
    rd(8'h04, d); chk("R3 busy bit", {29'b0, d[2:0]}, 32'h4);
    // R7 launch while busy ignored
    wr(8'h04, ctl(1'b1, 3'd2, 8'd0, 1'b0, 1'b0), 4'hF);
    chk("R7 still presenting", {29'b0, cmd_type}, 32'h1);
    // R12 host buffer write while busy ignored
    wr(8'h48, 32'hDEAD_BEEF, 4'hF);
    wait_idle();
    rd(8'h48, d); chk("R12 buffer unchanged", d, 32'h0F0F_0F0F);
    rd(8'h04, d); chk("R4 done after ack", {29'b0, d[2:0]}, 32'h1);
    chk("R10 engine byte0", {24'b0, seen[0]}, 32'hDD);
    chk("R10 engine byte1", {24'b0, seen[1]}, 32'h55);
    chk("R10 engine byte7", {24'b0, seen[7]}, 32'h11);

    // R6 zero has no effect, one clears
    wr(8'h04, ctl(1'b0, 3'd0, 8'd0, 1'b0, 1'b1), 4'hF);
    rd(8'h04, d); chk("R6 done kept", {31'b0, d[0]}, 32'h1);
    wr(8'h04, ctl(1'b0, 3'd0, 8'd0, 1'b1, 1'b0), 4'hF);
    rd(8'h04, d); chk("R6 done cleared", {31'b0, d[0]}, 32'h0);

    // R5 erase 64 KiB presents zero length
    wr(8'h00, 32'h0001_0000, 4'hF);
    launch(3'd3, 8'd5, 1'b0, 1'b1, 32'h0001_0000, 7'd0);
    chk("R5 erase length", {25'b0, cmd_len}, 32'h0);
    wait_idle();

    // R11 read of 4 bytes fills buffer from engine
    wr(8'h00, 32'h0000_2000, 4'hF);
    launch(3'd0, 8'd3, 1'b1, 1'b1, 32'h0000_2000, 7'd4);
    wait_idle();
    rd(8'h40, d); chk("R11 drained word", d, 32'hA3A2_A1A0);

    // R13 failing status read
    resp_err = 1'b1;
    launch(3'd4, 8'd0, 1'b1, 1'b1, 32'h0000_2000, 7'd1);
    wait_idle();
    resp_err = 1'b0;
    rd(8'h04, d); chk("R13 failed not done", {30'b0, d[1:0]}, 32'h2);

    // R6 launch clears stale failed flag
    launch(3'd2, 8'd0, 1'b1, 1'b1, 32'h0000_2000, 7'd0);
    rd(8'h04, d); chk("R6 stale cleared at launch", {30'b0, d[1:0]}, 32'h0);
    wait_idle();
    rd(8'h04, d); chk("R6 clean completion", {30'b0, d[1:0]}, 32'h1);

    // R8 oversized length
    launch(3'd0, 8'd64, 1'b1, 1'b0, 32'h0, 7'd0);
    chk("R8 no request", {31'b0, cmd_req}, 32'h0);
    rd(8'h04, d); chk("R8 failed set", {29'b0, d[2:0]}, 32'h2);

    // R9 unknown operation
    wr(8'h04, ctl(1'b0, 3'd0, 8'd0, 1'b1, 1'b1), 4'hF);
    launch(3'd6, 8'd1, 1'b0, 1'b0, 32'h0, 7'd0);
    chk("R9 no request", {31'b0, cmd_req}, 32'h0);
    rd(8'h04, d); chk("R9 failed set", {29'b0, d[2:0]}, 32'h2);

    repeat (10) @(negedge clk);
    chk("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
    summary();
  end
endmodule